// File: doc/BRIEF.md
# Secondary Display Timing Generator

This block produces the raster timing for a second display pipe. Four configuration words set the horizontal and vertical totals, active sizes, sync positions, sync widths and sync polarities, and a control word sets double scan and three suppression bits. From these the block drives hsync, vsync, a display-enable strobe and the current pixel coordinates. Horizontal totals and active widths are given in 8-pixel character units. The vertical counter steps once per output line.

Timing words written by software go into a staging copy. The staging copy moves into the working copy only at the end of a frame, so every frame is drawn with one consistent timing. From the write until that frame boundary, display enable is held low. A sticky status flag marks the start of each vertical sync. Software clears the flag by pulsing an acknowledge input.

The suppression bits implement the usual monitor power states. On leaves everything running. Standby stops hsync and the display. Suspend stops vsync and the display. Off stops all three. A suppressed sync sits at its inactive level.

Top module: `disp_timing_gen`

## Requirements
- R1: Word select 0 holds the horizontal total minus one in characters in bits 9:0 and the active width minus one in characters in bits 25:16. One line lasts (bits 9:0 + 1) × 8 clocks, and the first (bits 25:16 + 1) × 8 pixels of each line are active.
- R2: Word select 1 holds the hsync start pixel in bits 12:0 and the hsync width in characters in bits 21:16. A width of 0 is treated as 1. Hsync is asserted for pixels x with start ≤ x < start + 8 × width.
- R3: Word select 2 holds the vertical total minus one in bits 15:0 and the active height minus one in bits 31:16, both in lines. A frame lasts (bits 15:0 + 1) lines, and lines below (bits 31:16 + 1) are active.
- R4: Word select 3 holds the vsync start line minus one in bits 11:0 and the vsync width in lines in bits 20:16. A width of 0 is treated as 1. Vsync is asserted on lines y with start ≤ y < start + width.
- R5: Bit 23 of word select 1 makes hsync active-low, and bit 23 of word select 3 makes vsync active-low. A suppressed sync holds its inactive level.
- R6: In the control word (select 4), bit 0 suppresses hsync, bit 1 suppresses vsync and bit 2 suppresses display enable. A change to these bits takes effect on the clock after the write.
- R7: The interrupt flag goes high one clock after the first pixel of the vsync start line. A one-clock acknowledge pulse clears it. If a set and an acknowledge fall on the same clock, the set wins.
- R8: A write to any timing word (selects 0 to 3) forces display enable low from the next clock until the next frame boundary.
- R9: Timing words and the double-scan bit take effect only at the frame boundary, where both counters restart at 0.
- R10: Control bit 3 selects double scan. The vertical fields then count output lines, and the reported y is the line number divided by two.
- R11: The x and y outputs are 0 whenever display enable is low. Otherwise they give the current pixel and line.
- R12: While reset is held, the working timing is all zeros (one 8-pixel line per frame), display enable is high at x = 0, y = 0, hsync is high, and vsync and the interrupt flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 3 | Word select: 0 h total, 1 h sync, 2 v total, 3 v sync, 4 control |
| cfg_wdata | input | 32 | Configuration word data |
| irq_ack | input | 1 | Write-one acknowledge for the vsync flag |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| px_x_o | output | 13 | Pixel x coordinate, 0 outside the active area |
| px_y_o | output | 16 | Pixel y coordinate, 0 outside the active area |
| irq_o | output | 1 | Sticky vsync-start flag |

## Verification
The main comparison runs over one full frame for each of four timings. The first timing uses ordinary positive syncs. The second uses active-low syncs with width fields of zero, which separates the clamp from a missing sync. The third uses double scan, with an hsync that runs past the line end and a vsync two lines high. The fourth puts both syncs outside the frame, so they must never assert. Every pixel's hsync, vsync, enable and coordinates are compared with a model built from the field rules, and the following cycle must start a new frame at (0,0). Directed runs then try each of the four power states and confirm the inactive levels under both polarities. They also time the vsync flag against the sync edge and its acknowledge, and rewrite a sync word in the middle of a frame. That last case shows the old timing continuing and the display staying blank until the boundary.

// File: rtl/stg_pkg.sv
// Shared field widths, word selects and the working-timing record for the
// secondary display timing generator. Widths follow the configuration word
// layout, which software packs.
package stg_pkg;
    localparam int HCH_W   = 10;  // horizontal total/active, characters
    localparam int HSS_W   = 13;  // hsync start, pixels
    localparam int HSW_W   = 6;   // hsync width, characters
    localparam int VLN_W   = 16;  // vertical total/active, lines
    localparam int VSS_W   = 12;  // vsync start minus one, lines
    localparam int VSW_W   = 5;   // vsync width, lines
    localparam int HI_LSB  = 16;  // lsb of the upper field in a word
    localparam int POL_BIT = 23;  // active-low sync select
    localparam int SEL_W   = 3;

    localparam logic [SEL_W-1:0] SEL_HTOT  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_HSYNC = 3'd1;
    localparam logic [SEL_W-1:0] SEL_VTOT  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_VSYNC = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd4;

    localparam int CTL_HS_OFF = 0;
    localparam int CTL_VS_OFF = 1;
    localparam int CTL_DE_OFF = 2;
    localparam int CTL_DBL    = 3;

    typedef struct packed {
        logic [HCH_W-1:0] htot;
        logic [HCH_W-1:0] hact;
        logic [HSS_W-1:0] hs_start;
        logic [HSW_W-1:0] hs_wid;
        logic             hs_pol;
        logic [VLN_W-1:0] vtot;
        logic [VLN_W-1:0] vact;
        logic [VSS_W-1:0] vs_start;
        logic [VSW_W-1:0] vs_wid;
        logic             vs_pol;
        logic             dbl;
    } tmg_t;
endpackage

// File: rtl/stg_cfg_regs.sv
// Configuration store. Writes land in a staging record; the working record
// copies the staging record only at a frame boundary. Suppression bits act at
// once. A timing write raises a pending flag that blanks the display until the
// boundary. Assumes writes are single-cycle strobes.
module stg_cfg_regs
    import stg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             frame_end,
    output tmg_t             act_o,
    output logic             hs_off_o,
    output logic             vs_off_o,
    output logic             de_off_o,
    output logic             pending_o
);
    tmg_t stage_q;
    tmg_t act_q;
    logic pend_q;
    logic [2:0] off_q;
    logic timing_wr;

    assign timing_wr = cfg_we && (cfg_sel < SEL_CTRL);

    // Capture written fields into the staging record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_HTOT: begin
                    stage_q.htot <= cfg_wdata[HCH_W-1:0];
                    stage_q.hact <= cfg_wdata[HI_LSB +: HCH_W];
                end
                SEL_HSYNC: begin
                    stage_q.hs_start <= cfg_wdata[HSS_W-1:0];
                    stage_q.hs_wid   <= cfg_wdata[HI_LSB +: HSW_W];
                    stage_q.hs_pol   <= cfg_wdata[POL_BIT];
                end
                SEL_VTOT: begin
                    stage_q.vtot <= cfg_wdata[VLN_W-1:0];
                    stage_q.vact <= cfg_wdata[HI_LSB +: VLN_W];
                end
                SEL_VSYNC: begin
                    stage_q.vs_start <= cfg_wdata[VSS_W-1:0];
                    stage_q.vs_wid   <= cfg_wdata[HI_LSB +: VSW_W];
                    stage_q.vs_pol   <= cfg_wdata[POL_BIT];
                end
                SEL_CTRL: stage_q.dbl <= cfg_wdata[CTL_DBL];
                default: ;
            endcase
        end
    end

    // Suppression bits follow the control word immediately.
    always_ff @(posedge clk) begin
        if (!rst_n)
            off_q <= '0;
        else if (cfg_we && cfg_sel == SEL_CTRL)
            off_q <= {cfg_wdata[CTL_DE_OFF], cfg_wdata[CTL_VS_OFF], cfg_wdata[CTL_HS_OFF]};
    end

    // Working record moves only at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (frame_end)
            act_q <= stage_q;
    end

    // Pending blank: a timing write wins over the boundary in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (timing_wr)
            pend_q <= 1'b1;
        else if (frame_end)
            pend_q <= 1'b0;
    end

    assign act_o     = act_q;
    assign hs_off_o  = off_q[0];
    assign vs_off_o  = off_q[1];
    assign de_off_o  = off_q[2];
    assign pending_o = pend_q;
endmodule

// File: rtl/stg_scan_ctr.sv
// Pixel and line counters. A line ends at the last pixel of its last
// character; a frame ends at the last pixel of the last line. Assumes the
// totals change only at the frame boundary this module reports.
module stg_scan_ctr
    import stg_pkg::*;
#(
    parameter  int CHAR_SH = 3,
    localparam int HPX_W   = HCH_W + CHAR_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HCH_W-1:0] htot,
    input  logic [VLN_W-1:0] vtot,
    output logic [HPX_W-1:0] hcnt_o,
    output logic [VLN_W-1:0] vcnt_o,
    output logic             frame_end_o
);
    logic [HPX_W-1:0] h_q;
    logic [VLN_W-1:0] v_q;
    logic h_end;
    logic v_end;

    assign h_end = (h_q == {htot, {CHAR_SH{1'b1}}});
    assign v_end = (v_q == vtot);

    // Advance the raster position one pixel per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (h_end) begin
            h_q <= '0;
            v_q <= v_end ? '0 : v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    assign hcnt_o      = h_q;
    assign vcnt_o      = v_q;
    assign frame_end_o = h_end && v_end;
endmodule

// File: rtl/stg_sync_out.sv
// Sync windows, display enable, coordinates and the sticky vsync flag, all
// decoded from the counters and the working record. Widths of zero clamp
// to one. Suppressed syncs rest at their inactive level.
module stg_sync_out
    import stg_pkg::*;
#(
    parameter  int CHAR_SH = 3,
    localparam int HPX_W   = HCH_W + CHAR_SH,
    localparam int CW      = ((HPX_W > VLN_W) ? HPX_W : VLN_W) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HPX_W-1:0] hcnt,
    input  logic [VLN_W-1:0] vcnt,
    input  logic [HCH_W-1:0] hact,
    input  logic [HSS_W-1:0] hs_start,
    input  logic [HSW_W-1:0] hs_wid,
    input  logic             hs_pol,
    input  logic [VLN_W-1:0] vact,
    input  logic [VSS_W-1:0] vs_start,
    input  logic [VSW_W-1:0] vs_wid,
    input  logic             vs_pol,
    input  logic             dbl,
    input  logic             hs_off,
    input  logic             vs_off,
    input  logic             de_off,
    input  logic             pending,
    input  logic             irq_ack,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [HPX_W-1:0] px_x_o,
    output logic [VLN_W-1:0] px_y_o,
    output logic             irq_o,
    output logic             vs_hit_o
);
    logic [HSW_W-1:0] hw;
    logic [VSW_W-1:0] vw;
    logic [CW-1:0] hx, hs_lo, hs_hi, vy, vs_lo, vs_hi;
    logic hs_act, vs_act, de_raw, de;
    logic irq_q;

    // Sync windows with zero widths clamped to one unit.
    always_comb begin
        hw     = (hs_wid == '0) ? HSW_W'(1) : hs_wid;
        vw     = (vs_wid == '0) ? VSW_W'(1) : vs_wid;
        hx     = CW'(hcnt);
        vy     = CW'(vcnt);
        hs_lo  = CW'(hs_start);
        hs_hi  = hs_lo + (CW'(hw) << CHAR_SH);
        vs_lo  = CW'(vs_start) + CW'(1);
        vs_hi  = vs_lo + CW'(vw);
        hs_act = (hx >= hs_lo) && (hx < hs_hi);
        vs_act = (vy >= vs_lo) && (vy < vs_hi);
    end

    // Active area, blanking by control or by a pending rewrite.
    always_comb begin
        de_raw = (hcnt[HPX_W-1:CHAR_SH] <= hact) && (vcnt <= vact);
        de     = de_raw && !de_off && !pending;
    end

    assign hsync_o  = hs_off ? hs_pol : (hs_act ^ hs_pol);
    assign vsync_o  = vs_off ? vs_pol : (vs_act ^ vs_pol);
    assign de_o     = de;
    assign px_x_o   = de ? hcnt : '0;
    assign px_y_o   = de ? (dbl ? (vcnt >> 1) : vcnt) : '0;
    assign vs_hit_o = (hcnt == '0) && (vy == vs_lo);

    // Sticky vsync-start flag; a set beats an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (vs_hit_o)
            irq_q <= 1'b1;
        else if (irq_ack)
            irq_q <= 1'b0;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/disp_timing_gen.sv
// Secondary display timing generator top. It ties the configuration store,
// the raster counters and the output decode together. Assumes one pixel
// per clock and a single synchronous clock domain.
module disp_timing_gen
    import stg_pkg::*;
#(
    parameter  int CHAR_PX = 8,
    localparam int CHAR_SH = $clog2(CHAR_PX),
    localparam int HPX_W   = HCH_W + CHAR_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             irq_ack,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [HPX_W-1:0] px_x_o,
    output logic [VLN_W-1:0] px_y_o,
    output logic             irq_o
);
    tmg_t act;
    logic hs_off, vs_off, de_off, pending;
    logic frame_end, vs_hit;
    logic [HPX_W-1:0] hcnt;
    logic [VLN_W-1:0] vcnt;

    stg_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .frame_end (frame_end),
        .act_o     (act),
        .hs_off_o  (hs_off),
        .vs_off_o  (vs_off),
        .de_off_o  (de_off),
        .pending_o (pending)
    );

    stg_scan_ctr #(.CHAR_SH(CHAR_SH)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .htot        (act.htot),
        .vtot        (act.vtot),
        .hcnt_o      (hcnt),
        .vcnt_o      (vcnt),
        .frame_end_o (frame_end)
    );

    stg_sync_out #(.CHAR_SH(CHAR_SH)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .hcnt     (hcnt),
        .vcnt     (vcnt),
        .hact     (act.hact),
        .hs_start (act.hs_start),
        .hs_wid   (act.hs_wid),
        .hs_pol   (act.hs_pol),
        .vact     (act.vact),
        .vs_start (act.vs_start),
        .vs_wid   (act.vs_wid),
        .vs_pol   (act.vs_pol),
        .dbl      (act.dbl),
        .hs_off   (hs_off),
        .vs_off   (vs_off),
        .de_off   (de_off),
        .pending  (pending),
        .irq_ack  (irq_ack),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .de_o     (de_o),
        .px_x_o   (px_x_o),
        .px_y_o   (px_y_o),
        .irq_o    (irq_o),
        .vs_hit_o (vs_hit)
    );
endmodule

// File: rtl/stg_checker.sv
// Property checker for the timing generator, attached by bind. It watches
// ports together with signals that different submodules drive.
module stg_checker
    import stg_pkg::*;
#(
    parameter  int CHAR_SH = 3,
    localparam int HPX_W   = HCH_W + CHAR_SH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [SEL_W-1:0] cfg_sel,
    input logic             irq_ack,
    input logic             hsync_o,
    input logic             de_o,
    input logic             irq_o,
    input logic             frame_end,
    input logic             vs_hit,
    input tmg_t             act,
    input logic [HPX_W-1:0] hcnt,
    input logic             hs_off
);
    // R8: a timing write blanks the display on the following clock.
    a_r8_write_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel < SEL_CTRL) |=> !de_o);

    // R6: suppressed hsync rests at its inactive level.
    a_r6_hsync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hs_off |-> (hsync_o == act.hs_pol));

    // R7: the vsync start sets the flag on the next clock.
    a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        vs_hit |=> irq_o);

    // R7: an acknowledge with no set clears the flag.
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !vs_hit) |=> !irq_o);

    // R9: the working timing holds between frame boundaries.
    a_r9_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(act));

    // R1: the pixel counter never passes the programmed line length.
    a_r1_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= {act.htot, {CHAR_SH{1'b1}}});
endmodule

bind disp_timing_gen stg_checker #(.CHAR_SH(CHAR_SH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .irq_ack   (irq_ack),
    .hsync_o   (hsync_o),
    .de_o      (de_o),
    .irq_o     (irq_o),
    .frame_end (frame_end),
    .vs_hit    (vs_hit),
    .act       (act),
    .hcnt      (hcnt),
    .hs_off    (hs_off)
);

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NROW = 4;
    // Per row: h total word, h sync word, v total word, v sync word, control.
    localparam logic [31:0] ROWS [NROW][5] = '{
        '{32'h0001_0003, 32'h0001_0014, 32'h0002_0005, 32'h0001_0003, 32'h0000_0000},
        '{32'h0003_0004, 32'h0080_0008, 32'h0003_0003, 32'h0080_0000, 32'h0000_0000},
        '{32'h0001_0002, 32'h0002_0010, 32'h0005_0007, 32'h0002_0005, 32'h0000_0008},
        '{32'h0000_0001, 32'h0001_0064, 32'h0000_0002, 32'h0001_0009, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        irq_ack = 1'b0;
    logic        hsync_o, vsync_o, de_o, irq_o;
    logic [12:0] px_x_o;
    logic [15:0] px_y_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    disp_timing_gen i_disp_timing_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .irq_ack   (irq_ack),
        .hsync_o   (hsync_o),
        .vsync_o   (vsync_o),
        .de_o      (de_o),
        .px_x_o    (px_x_o),
        .px_y_o    (px_y_o),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge after the write edge.
    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // Program a row and return at the first cycle of the new frame (0,0).
    task automatic apply_row(input int r);
        int g;
        wr(3'd4, ROWS[r][4]);
        wr(3'd0, ROWS[r][0]);
        wr(3'd1, ROWS[r][1]);
        wr(3'd2, ROWS[r][2]);
        wr(3'd3, ROWS[r][3]);
        g = 0;
        while (!de_o && g < 1000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic count_win(input int n, output int hs, output int vs, output int de);
        hs = 0; vs = 0; de = 0;
        for (int i = 0; i < n; i++) begin
            hs += int'(hsync_o); vs += int'(vsync_o); de += int'(de_o);
            @(negedge clk);
        end
    endtask

    // Compare one whole frame against a model built from the field rules.
    task automatic run_row(input int r);
        int ht, ha, hs0, hw, vt, va, vs0, vw;
        bit hp, vp, dbl;
        int e_hs, e_vs, e_de, e_px;
        ht  = (int'(ROWS[r][0][9:0]) + 1) * 8;
        ha  = (int'(ROWS[r][0][25:16]) + 1) * 8;
        hs0 = int'(ROWS[r][1][12:0]);
        hw  = int'(ROWS[r][1][21:16]); if (hw == 0) hw = 1;
        hp  = ROWS[r][1][23];
        vt  = int'(ROWS[r][2][15:0]) + 1;
        va  = int'(ROWS[r][2][31:16]) + 1;
        vs0 = int'(ROWS[r][3][11:0]) + 1;
        vw  = int'(ROWS[r][3][20:16]); if (vw == 0) vw = 1;
        vp  = ROWS[r][3][23];
        dbl = ROWS[r][4][3];
        e_hs = 0; e_vs = 0; e_de = 0; e_px = 0;
        apply_row(r);
        for (int c = 0; c < ht * vt; c++) begin
            int x, y, ex, ey;
            bit ehs, evs, ede;
            x = c % ht; y = c / ht;
            ehs = ((x >= hs0) && (x < hs0 + hw * 8)) ^ hp;
            evs = ((y >= vs0) && (y < vs0 + vw)) ^ vp;
            ede = (x < ha) && (y < va);
            ex  = ede ? x : 0;
            ey  = ede ? (dbl ? y / 2 : y) : 0;
            if (hsync_o !== ehs) e_hs++;
            if (vsync_o !== evs) e_vs++;
            if (de_o !== ede) e_de++;
            if (int'(px_x_o) != ex || int'(px_y_o) != ey) e_px++;
            @(negedge clk);
        end
        check(e_hs == 0, $sformatf("R2/R5 row %0d hsync mismatches", r), e_hs, 0);
        check(e_vs == 0, $sformatf("R4/R5 row %0d vsync mismatches", r), e_vs, 0);
        check(e_de == 0, $sformatf("R1/R3 row %0d enable mismatches", r), e_de, 0);
        check(e_px == 0, $sformatf("R10/R11 row %0d coordinate mismatches", r), e_px, 0);
        check(de_o && px_x_o == 0 && px_y_o == 0,
              $sformatf("R1/R3 row %0d frame wrap to (0,0)", r), int'(px_x_o) + int'(px_y_o), 0);
    endtask

    initial begin
        int hs, vs, de, g;
        bit prev;
        // R12: reset state, sampled while reset is held
        repeat (3) @(negedge clk);
        check(de_o == 1'b1, "R12 enable in reset", int'(de_o), 1);
        check(px_x_o == 0 && px_y_o == 0, "R12 coordinates in reset", int'(px_x_o) + int'(px_y_o), 0);
        check(hsync_o == 1'b1, "R12 hsync in reset", int'(hsync_o), 1);
        check(vsync_o == 1'b0 && irq_o == 1'b0, "R12 vsync and flag in reset",
              int'(vsync_o) + int'(irq_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int r = 0; r < NROW; r++) run_row(r);

        // R8 and R9: mid-frame rewrite of the hsync word
        apply_row(0);
        repeat (32) @(negedge clk);
        wr(3'd1, 32'h0001_0004);
        check(de_o == 1'b0, "R8 enable low after rewrite", int'(de_o), 0);
        repeat (51) @(negedge clk);
        check(hsync_o == 1'b1, "R9 old hsync start kept in current frame", int'(hsync_o), 1);
        check(de_o == 1'b0, "R8 enable still low before boundary", int'(de_o), 0);
        g = 0;
        while (!de_o && g < 1000) begin
            @(negedge clk);
            g++;
        end
        check(g == 108, "R8 blank lasts to frame boundary", g, 108);
        check(px_x_o == 0 && px_y_o == 0, "R9 boundary restarts at (0,0)",
              int'(px_x_o) + int'(px_y_o), 0);
        repeat (4) @(negedge clk);
        check(hsync_o == 1'b1, "R9 new hsync start active", int'(hsync_o), 1);
        repeat (16) @(negedge clk);
        check(hsync_o == 1'b0, "R9 old hsync start gone", int'(hsync_o), 0);

        // R6: power states with positive syncs
        apply_row(0);
        wr(3'd4, 32'd5);
        count_win(192, hs, vs, de);
        check(hs == 0 && de == 0, "R6 standby hsync+enable", hs + de, 0);
        check(vs == 32, "R6 standby vsync", vs, 32);
        wr(3'd4, 32'd6);
        count_win(192, hs, vs, de);
        check(vs == 0 && de == 0, "R6 suspend vsync+enable", vs + de, 0);
        check(hs == 48, "R6 suspend hsync", hs, 48);
        wr(3'd4, 32'd7);
        count_win(192, hs, vs, de);
        check(hs + vs + de == 0, "R6 off all quiet", hs + vs + de, 0);
        wr(3'd4, 32'd0);
        count_win(192, hs, vs, de);
        check(hs == 48 && vs == 32 && de == 48, "R6 on all running", hs * 10000 + vs * 100 + de, 483248);

        // R5: inactive levels with active-low syncs
        apply_row(1);
        wr(3'd4, 32'd7);
        count_win(160, hs, vs, de);
        check(hs == 160 && vs == 160, "R5 suppressed low-active syncs stay high", hs + vs, 320);
        wr(3'd4, 32'd0);
        count_win(160, hs, vs, de);
        check(hs == 128 && vs == 120, "R5 low-active sync high counts", hs * 1000 + vs, 128120);

        // R7: flag timing and acknowledge
        apply_row(0);
        ack();
        prev = vsync_o;
        g = 0;
        while (g < 400) begin
            @(negedge clk);
            g++;
            if (vsync_o && !prev) break;
            prev = vsync_o;
        end
        check(irq_o == 1'b0, "R7 flag low on first vsync cycle", int'(irq_o), 0);
        @(negedge clk);
        check(irq_o == 1'b1, "R7 flag set one clock after vsync start", int'(irq_o), 1);
        ack();
        check(irq_o == 1'b0, "R7 acknowledge clears flag", int'(irq_o), 0);
        repeat (100) @(negedge clk);
        check(irq_o == 1'b0, "R7 flag stays clear until next vsync", int'(irq_o), 0);
        g = 0;
        while (!irq_o && g < 300) begin
            @(negedge clk);
            g++;
        end
        check(g == 91, "R7 flag sets again next frame", g, 91);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule